// File: doc/BRIEF.md
# Shift Unit with Flags

This block is a single-stage 32-bit shifter that produces a result word and a fresh set of status flags. It covers five operations: a left shift, a logical right shift, an arithmetic right shift, and two double-width shifts. The double-width shifts feed the vacated positions of the destination from a second source word. All five are built from one wide shift of a concatenated word, so every count from 1 to 31 takes the same single cycle.

The caller presents a destination word, a source word, a count, an operation code and the current flag values, and raises `in_valid`. One clock later the result and the carry, overflow, sign, zero and parity flags are on the outputs with `out_valid` high. The outputs stay as they are until the next valid request. The count is masked to its low five bits. A masked count of zero returns the destination and the incoming flags untouched, so the unit can sit in a datapath where the flags must survive a shift by zero.

Top module: `shift_flags_unit`

## Requirements
- R1: Only the low five bits of `in_count` take effect, so a count of n+32 gives the same result and flags as a count of n.
- R2: Operation code 0 (left shift) moves the destination toward the most significant end by the masked count and puts zeros into the vacated low bits. Carry becomes the last bit that leaves the top end.
- R3: Operation code 1 (logical right shift) puts zeros into the vacated high bits. Operation code 2 (arithmetic right shift) copies the original sign bit into them. For both, carry becomes the last bit that leaves bit 0. For example, 0xFFFFFFE6 shifted arithmetically right by 2 gives 0xFFFFFFF9, and 21 shifted logically right by 1 gives 10 with carry 1.
- R4: Operation code 3 (double left) fills the low end of the destination with the most significant bits of the source. Operation code 4 (double right) fills the high end with the least significant bits of the source. Carry is the last destination bit shifted out.
- R5: A masked count of 0, or an operation code from 5 to 7, returns the destination unchanged and copies all five incoming flags to the outputs.
- R6: With a masked count of 1, overflow is set as follows. For codes 0 and 3 it is the result MSB XOR the new carry. For code 1 it is the original destination MSB. For code 2 it is 0. For code 4 it is the result MSB XOR the original destination MSB.
- R7: With a masked count from 2 to 31, overflow repeats the incoming overflow flag.
- R8: After any real shift, sign is the result MSB and zero is set when the result is all zeros. Parity is set when the low result byte has an even number of ones.
- R9: `out_valid` is high in exactly the cycle after a cycle with `in_valid` high. When `in_valid` is low, the result and flags outputs keep their values.
- R10: While `rst_n` is low, every output is 0.
- R11: The source word has no effect on operation codes 0, 1 and 2.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| in_valid | input | 1 | Request strobe |
| in_op | input | 3 | Operation code: 0 left, 1 logical right, 2 arithmetic right, 3 double left, 4 double right |
| in_dst | input | 32 | Word to shift |
| in_src | input | 32 | Fill word for the double shifts |
| in_count | input | 8 | Shift count; only the low five bits are used |
| in_cf | input | 1 | Incoming carry |
| in_of | input | 1 | Incoming overflow |
| in_sf | input | 1 | Incoming sign |
| in_zf | input | 1 | Incoming zero |
| in_pf | input | 1 | Incoming parity |
| out_valid | output | 1 | Result present |
| out_result | output | 32 | Shifted word |
| out_cf | output | 1 | Carry |
| out_of | output | 1 | Overflow |
| out_sf | output | 1 | Sign |
| out_zf | output | 1 | Zero |
| out_pf | output | 1 | Parity |

## Verification
The assertions assume a new request is not needed to hold the outputs: they tie each output change to the request of the previous cycle. They also assume the incoming flag inputs are stable when `in_valid` is sampled, so a pass-through compare against `$past` of those inputs is meaningful. The stimulus drives every input at the falling edge, raises `in_valid` for one cycle per request, and leaves idle cycles between requests. Those idle cycles exercise the hold rule, and every request is judged from a single sampled clock edge. The sweep covers every operation code, including the three unused ones, and every count from 0 to 63. It uses several operand patterns, with varying incoming flag values so that the overflow-repeat case can be told apart from a computed overflow.

// File: rtl/shift_flags_unit.sv
module shift_flags_unit #(
  parameter int WIDTH    = 32,
  parameter int CNT_IN_W = 8
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                in_valid,
  input  logic [2:0]          in_op,
  input  logic [WIDTH-1:0]    in_dst,
  input  logic [WIDTH-1:0]    in_src,
  input  logic [CNT_IN_W-1:0] in_count,
  input  logic                in_cf,
  input  logic                in_of,
  input  logic                in_sf,
  input  logic                in_zf,
  input  logic                in_pf,
  output logic                out_valid,
  output logic [WIDTH-1:0]    out_result,
  output logic                out_cf,
  output logic                out_of,
  output logic                out_sf,
  output logic                out_zf,
  output logic                out_pf
);
  localparam int CW = $clog2(WIDTH);
  localparam logic [2:0] OP_SHL  = 3'd0;
  localparam logic [2:0] OP_SHR  = 3'd1;
  localparam logic [2:0] OP_SAR  = 3'd2;
  localparam logic [2:0] OP_DSHL = 3'd3;
  localparam logic [2:0] OP_DSHR = 3'd4;

  logic [CW-1:0]    n;
  logic             do_shift, is_left;
  logic [WIDTH-1:0] fill_l, fill_r, res_l, res_r, res;
  logic             cf_l, cf_r, cf, of_calc;
  logic             unused_cnt_hi;

  assign n             = in_count[CW-1:0];
  assign unused_cnt_hi = ^in_count[CNT_IN_W-1:CW];
  assign do_shift      = (n != '0) && (in_op <= OP_DSHR);
  assign is_left       = (in_op == OP_SHL) || (in_op == OP_DSHL);

  assign fill_l = (in_op == OP_DSHL) ? in_src : '0;
  assign fill_r = (in_op == OP_DSHR) ? in_src :
                  (in_op == OP_SAR)  ? {WIDTH{in_dst[WIDTH-1]}} : '0;

  assign {cf_l, res_l} = (WIDTH+1)'({1'b0, in_dst, fill_l} >> (WIDTH - int'(n)));
  assign {res_r, cf_r} = (WIDTH+1)'({fill_r, in_dst, 1'b0} >> n);

  assign res = is_left ? res_l : res_r;
  assign cf  = is_left ? cf_l  : cf_r;

  always_comb begin
    of_calc = in_of;
    if (n == CW'(1)) begin
      case (in_op)
        OP_SHL, OP_DSHL: of_calc = res[WIDTH-1] ^ cf;
        OP_SHR:          of_calc = in_dst[WIDTH-1];
        OP_SAR:          of_calc = 1'b0;
        OP_DSHR:         of_calc = res[WIDTH-1] ^ in_dst[WIDTH-1];
        default:         of_calc = in_of;
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      out_valid  <= 1'b0;
      out_result <= '0;
      out_cf     <= 1'b0;
      out_of     <= 1'b0;
      out_sf     <= 1'b0;
      out_zf     <= 1'b0;
      out_pf     <= 1'b0;
    end else begin
      out_valid <= in_valid;
      if (in_valid) begin
        if (do_shift) begin
          out_result <= res;
          out_cf     <= cf;
          out_of     <= of_calc;
          out_sf     <= res[WIDTH-1];
          out_zf     <= (res == '0);
          out_pf     <= ~^res[7:0];
        end else begin
          out_result <= in_dst;
          out_cf     <= in_cf;
          out_of     <= in_of;
          out_sf     <= in_sf;
          out_zf     <= in_zf;
          out_pf     <= in_pf;
        end
      end
    end
  end
endmodule

// File: rtl/shift_flags_unit_chk.sv
module shift_flags_unit_chk #(
  parameter int WIDTH    = 32,
  parameter int CNT_IN_W = 8
) (
  input logic                clk,
  input logic                rst_n,
  input logic                in_valid,
  input logic [2:0]          in_op,
  input logic [WIDTH-1:0]    in_dst,
  input logic [CNT_IN_W-1:0] in_count,
  input logic                in_cf,
  input logic                in_of,
  input logic                out_valid,
  input logic [WIDTH-1:0]    out_result,
  input logic                out_cf,
  input logic                out_of,
  input logic                out_sf,
  input logic                out_zf,
  input logic                out_pf
);
  localparam int CW = $clog2(WIDTH);
  logic [CW-1:0] n;
  assign n = in_count[CW-1:0];

  AST_VALID_LATENCY: assert property (@(posedge clk) disable iff (!rst_n)
    in_valid |=> out_valid); // R9
  AST_IDLE_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    !in_valid |=> $stable(out_result) && $stable(out_cf) && $stable(out_of)
                  && $stable(out_sf) && $stable(out_zf) && $stable(out_pf)); // R9
  AST_ZERO_COUNT_PASS: assert property (@(posedge clk) disable iff (!rst_n)
    in_valid && n == '0 |=> out_result == $past(in_dst) && out_cf == $past(in_cf)
                            && out_of == $past(in_of)); // R5
  AST_SAR_ONE_NO_OF: assert property (@(posedge clk) disable iff (!rst_n)
    in_valid && in_op == 3'd2 && n == CW'(1) |=> !out_of); // R6
  AST_LEFT_ZERO_FILL: assert property (@(posedge clk) disable iff (!rst_n)
    in_valid && in_op == 3'd0 && n != '0 |=> !out_result[0]); // R2
  AST_MULTI_OF_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    in_valid && in_op <= 3'd4 && n > CW'(1) |=> out_of == $past(in_of)); // R7
  AST_SIGN_TRACK: assert property (@(posedge clk) disable iff (!rst_n)
    in_valid && in_op <= 3'd4 && n != '0 |=> out_sf == out_result[WIDTH-1]); // R8
endmodule

bind shift_flags_unit shift_flags_unit_chk #(.WIDTH(WIDTH), .CNT_IN_W(CNT_IN_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_op(in_op), .in_dst(in_dst),
  .in_count(in_count), .in_cf(in_cf), .in_of(in_of), .out_valid(out_valid),
  .out_result(out_result), .out_cf(out_cf), .out_of(out_of), .out_sf(out_sf),
  .out_zf(out_zf), .out_pf(out_pf)
);

// File: tb/shift_flags_unit_tb.sv
module shift_flags_unit_tb;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        in_valid = 1'b0;
  logic [2:0]  in_op = '0;
  logic [31:0] in_dst = '0, in_src = '0;
  logic [7:0]  in_count = '0;
  logic        in_cf = 0, in_of = 0, in_sf = 0, in_zf = 0, in_pf = 0;
  logic        out_valid, out_cf, out_of, out_sf, out_zf, out_pf;
  logic [31:0] out_result;
  int checks = 0, failures = 0;
  bit done = 0;

  always #5 clk = ~clk;

  shift_flags_unit u_dut (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_op(in_op), .in_dst(in_dst),
    .in_src(in_src), .in_count(in_count), .in_cf(in_cf), .in_of(in_of), .in_sf(in_sf),
    .in_zf(in_zf), .in_pf(in_pf), .out_valid(out_valid), .out_result(out_result),
    .out_cf(out_cf), .out_of(out_of), .out_sf(out_sf), .out_zf(out_zf), .out_pf(out_pf)
  );

  // returns {result, cf, of, sf, zf, pf}; bit-serial model
  function automatic logic [36:0] model(input logic [2:0] op, input logic [31:0] d,
                                        input logic [31:0] s, input logic [7:0] c,
                                        input logic [4:0] fin);
    logic [31:0] r = d;
    logic [31:0] sc = s;
    logic cf = 1'b0, of;
    int k = c % 32;
    if (k == 0 || op > 3'd4) return {d, fin};
    for (int i = 0; i < k; i++) begin
      case (op)
        3'd0: begin cf = r[31]; r = r * 2; end
        3'd1: begin cf = r[0]; r = r / 2; end
        3'd2: begin cf = r[0]; r = {r[31], r[31:1]}; end
        3'd3: begin cf = r[31]; r = {r[30:0], sc[31]}; sc = sc * 2; end
        default: begin cf = r[0]; r = {sc[0], r[31:1]}; sc = sc / 2; end
      endcase
    end
    of = fin[3];
    if (k == 1) begin
      case (op)
        3'd0, 3'd3: of = r[31] ^ cf;
        3'd1:       of = d[31];
        3'd2:       of = 1'b0;
        default:    of = r[31] ^ d[31];
      endcase
    end
    return {r, cf, of, r[31], r == 0, ~^r[7:0]};
  endfunction

  task automatic check(input string tag, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic run(input logic [2:0] op, input logic [31:0] d, input logic [31:0] s,
                     input logic [7:0] c, input logic [4:0] fin);
    logic [36:0] e;
    string rt, ft;
    int k = c % 32;
    e = model(op, d, s, c, fin);
    @(negedge clk);
    in_op = op; in_dst = d; in_src = s; in_count = c;
    {in_cf, in_of, in_sf, in_zf, in_pf} = fin;
    in_valid = 1'b1;
    @(negedge clk);
    in_valid = 1'b0;
    if (k == 0 || op > 3'd4) begin rt = "R5"; ft = "R5"; end
    else begin
      rt = (c > 31) ? "R1" : (op == 0) ? "R2" : (op <= 2) ? "R3 R11" : "R4";
      ft = (k == 1) ? "R6 R8" : "R7 R8";
    end
    check("R9 valid", 64'(out_valid), 64'(1'b1));
    check({rt, " result"}, 64'(out_result), 64'(e[36:5]));
    check({rt, " carry"}, 64'(out_cf), 64'(e[4]));
    check({ft, " flags"}, 64'({out_of, out_sf, out_zf, out_pf}), 64'(e[3:0]));
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      failures++;
      $display("FAIL watchdog expired");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    logic [31:0] pats [7] = '{32'hFFFFFF4B, 32'h00000015, 32'hFFFFFFE6, 32'h80000001,
                              32'h7FFFFFFF, 32'h00000000, 32'h12345678};
    logic [31:0] held;
    repeat (3) @(negedge clk);
    check("R10 reset", {out_valid, out_cf, out_of, out_sf, out_zf, out_pf, out_result},
          64'd0);
    rst_n = 1'b1;

    // literal examples
    run(3'd2, 32'hFFFFFFE6, 32'h0, 8'd2, 5'b0);
    check("R3 sar example", 64'(out_result), 64'(32'hFFFFFFF9));
    run(3'd1, 32'd21, 32'h0, 8'd1, 5'b0);
    check("R3 shr example", 64'({out_result, out_cf}), 64'({32'd10, 1'b1}));
    run(3'd0, 32'h15, 32'hFFFFFFFF, 8'd3, 5'b0);
    held = out_result;
    run(3'd0, 32'h15, 32'h00000000, 8'd3, 5'b0);
    check("R11 src ignored", 64'(out_result), 64'(held));
    check("R11 shl value", 64'(held), 64'(32'hA8));
    run(3'd3, 32'h0000000F, 32'hC0000000, 8'd2, 5'b0);
    check("R4 dshl value", 64'(out_result), 64'(32'h0000003F));

    for (int p = 0; p < 7; p++)
      for (int op = 0; op < 8; op++)
        for (int c = 0; c < 64; c++)
          run(3'(op), pats[p], (p[0] ? 32'hA5C30F96 : 32'h5A3CF069) ^ pats[(p+3)%7],
              8'(c + (c[0] ? 64 : 0)), 5'(p * 7 + op + c));

    held = out_result;
    @(negedge clk); @(negedge clk);
    check("R9 idle hold", 64'({out_valid, out_result}), 64'({1'b0, held}));

    done = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule